// File: doc/BRIEF.md
# Radio Event Timebase with Overflow Extension

This block keeps a 40-bit time reference for scheduling radio activity. A 16-bit period counter runs from zero up to a programmable period minus one. Each time it wraps, a 24-bit overflow counter advances on the same clock edge. Together the two halves form one 40-bit timestamp. The block records that timestamp when a frame-start delimiter is detected or when a transmission finishes, and it compares both halves against programmed values to produce exact event pulses. Those pulses can start receive or transmit, or they can raise interrupts.

There are two compare channels. Each channel has one 16-bit value checked against the period counter and one 24-bit value checked against the overflow counter, and each of the two checks has its own enable. An event pulse also sets a sticky per-channel flag, and software clears the flag by writing a one to it. Software reads the period count through a read strobe. The strobe latches the overflow count into a shadow register, so the two halves read back always belong to the same clock cycle.

Top module: `radio_evt_timer`

## Requirements
- R1: While `rst` is high on a clock edge, every output register goes to zero: both counters, the capture register, the shadow register, the events and the flags.
- R2: When `run` is high, the period counter advances by one per cycle. On a cycle where the count is at least `period_cfg - 1` (16-bit arithmetic, so a period of 0 means 65536 steps), the counter returns to 0 and the overflow counter increments on the same edge. If the period is lowered below the current count, the counter therefore wraps on the next edge.
- R3: When `run` is low, both counters hold their values.
- R4: `cap_sel` = 0 selects `sfd_pulse` as the capture source and `cap_sel` = 1 selects `txend_pulse`. On a cycle where the selected source is high, `cap_time` takes the value of {overflow, period} from that cycle and shows it from the next cycle on. The source that is not selected has no effect on `cap_time`.
- R5: In channel c, the low enable (`cmp_lo_en[c]`) requires the period count to equal bits [16c+15:16c] of `cmp_lo_val`. The high enable (`cmp_hi_en[c]`) requires the overflow count to equal bits [24c+23:24c] of `cmp_hi_val`. The channel matches when at least one enable is set and every enabled check holds in the same cycle. With neither enable set, the channel never matches.
- R6: `evt[c]` is high for exactly one cycle: the cycle after the first cycle of a run of matching cycles. It does not repeat while the match continues.
- R7: `flags[c]` sets on the same edge that raises `evt[c]`. It stays set until a cycle with `clr_flags[c]` high. A set and a clear in the same cycle leave the flag set.
- R8: `irq` is high exactly when any flag is set.
- R9: `low_val` always shows the live period count. A cycle with `low_rd` high copies that cycle's overflow count into `shadow_hi`, where it is held until the next `low_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable |
| period_cfg | input | 16 | Period length in cycles (0 means 65536) |
| sfd_pulse | input | 1 | Frame-start delimiter seen |
| txend_pulse | input | 1 | Transmission finished |
| cap_sel | input | 1 | Capture source: 0 frame start, 1 end of transmit |
| low_rd | input | 1 | Period-count read strobe; latches the overflow count into the shadow |
| clr_flags | input | 2 | Write-one-to-clear for the sticky flags |
| cmp_lo_val | input | 32 | Period compare values, channel c in bits [16c+15:16c] |
| cmp_hi_val | input | 48 | Overflow compare values, channel c in bits [24c+23:24c] |
| cmp_lo_en | input | 2 | Per-channel enable of the period compare |
| cmp_hi_en | input | 2 | Per-channel enable of the overflow compare |
| now_time | output | 40 | Live {overflow, period} timestamp |
| low_val | output | 16 | Live period count for the read path |
| shadow_hi | output | 24 | Overflow count latched by `low_rd` |
| cap_time | output | 40 | Captured timestamp |
| evt | output | 2 | One-cycle event pulses |
| flags | output | 2 | Sticky event flags |
| irq | output | 1 | OR of the flags |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the period wrap and a capture or read strobe: a strobe on the last count of a period must record the old overflow value, not the incremented one. The second pair is a flag being set by an event and cleared by software on the same edge. Random strobes are applied across periods of five cycles, and one phase holds the clear of channel 0 high permanently, so both collisions happen many times. Each cycle is judged against an arithmetic model built from the requirements, and that model says set wins over clear and that captures take the pre-edge time.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
    parameter int unsigned RT_PW  = 16;
    parameter int unsigned RT_OW  = 24;
    parameter int unsigned RT_TW  = RT_PW + RT_OW;

    typedef struct packed {
        logic [RT_OW-1:0] ovf;
        logic [RT_PW-1:0] cnt;
    } tstamp_t;

    typedef struct packed {
        logic             lo_en;
        logic             hi_en;
        logic [RT_PW-1:0] lo_val;
        logic [RT_OW-1:0] hi_val;
    } chan_cfg_t;

    function automatic logic at_period_end(input logic [RT_PW-1:0] cnt,
                                           input logic [RT_PW-1:0] per);
        logic [RT_PW-1:0] last;
        last = per - {{(RT_PW-1){1'b0}}, 1'b1};
        return cnt >= last;
    endfunction

    function automatic logic chan_hit(input chan_cfg_t cfg, input tstamp_t t);
        logic lo_ok;
        logic hi_ok;
        lo_ok = !cfg.lo_en || (t.cnt == cfg.lo_val);
        hi_ok = !cfg.hi_en || (t.ovf == cfg.hi_val);
        return (cfg.lo_en || cfg.hi_en) && lo_ok && hi_ok;
    endfunction
endpackage

// File: rtl/rt_timebase.sv
module rt_timebase
    import rtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [RT_PW-1:0] period_cfg,
    output tstamp_t          now
);
    tstamp_t t_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else if (run) begin
            if (at_period_end(t_q.cnt, period_cfg)) begin
                t_q.cnt <= '0;
                t_q.ovf <= t_q.ovf + 1'b1;
            end else begin
                t_q.cnt <= t_q.cnt + 1'b1;
            end
        end
    end

    assign now = t_q;

    p_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(t_q.cnt) && $stable(t_q.ovf)));

    p_carry_with_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(t_q.ovf) |-> (t_q.cnt == '0 && t_q.ovf == $past(t_q.ovf) + 1'b1));
endmodule

// File: rtl/rt_capture.sv
module rt_capture
    import rtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  tstamp_t          now,
    input  logic             sfd_pulse,
    input  logic             txend_pulse,
    input  logic             cap_sel,
    input  logic             low_rd,
    output tstamp_t          cap_q,
    output logic [RT_OW-1:0] shadow_q
);
    logic fire;
    assign fire = cap_sel ? txend_pulse : sfd_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            shadow_q <= '0;
        end else begin
            if (fire)   cap_q    <= now;
            if (low_rd) shadow_q <= now.ovf;
        end
    end

    p_cap_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !(cap_sel ? txend_pulse : sfd_pulse) |=> $stable(cap_q));

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !low_rd |=> $stable(shadow_q));
endmodule

// File: rtl/rt_compare_ch.sv
module rt_compare_ch
    import rtmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tstamp_t   now,
    input  chan_cfg_t cfg,
    input  logic      clr,
    output logic      evt_q,
    output logic      flag_q
);
    logic hit;
    logic hit_d;
    logic first;

    assign hit   = chan_hit(cfg, now);
    assign first = hit && !hit_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_d  <= 1'b0;
            evt_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            hit_d  <= hit;
            evt_q  <= first;
            flag_q <= first | (flag_q & ~clr);
        end
    end

    p_evt_single_r6: assert property (@(posedge clk) disable iff (rst)
        evt_q |=> !evt_q);

    p_evt_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> flag_q);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    p_disabled_silent_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg.lo_en && !cfg.hi_en) |=> !evt_q);
endmodule

// File: rtl/radio_evt_timer.sv
module radio_evt_timer
    import rtmr_pkg::*;
#(
    parameter int unsigned NCH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [RT_PW-1:0]     period_cfg,
    input  logic                 sfd_pulse,
    input  logic                 txend_pulse,
    input  logic                 cap_sel,
    input  logic                 low_rd,
    input  logic [NCH-1:0]       clr_flags,
    input  logic [NCH*RT_PW-1:0] cmp_lo_val,
    input  logic [NCH*RT_OW-1:0] cmp_hi_val,
    input  logic [NCH-1:0]       cmp_lo_en,
    input  logic [NCH-1:0]       cmp_hi_en,
    output logic [RT_TW-1:0]     now_time,
    output logic [RT_PW-1:0]     low_val,
    output logic [RT_OW-1:0]     shadow_hi,
    output logic [RT_TW-1:0]     cap_time,
    output logic [NCH-1:0]       evt,
    output logic [NCH-1:0]       flags,
    output logic                 irq
);
    tstamp_t now;
    tstamp_t cap;

    rt_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .period_cfg (period_cfg),
        .now        (now)
    );

    rt_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .now         (now),
        .sfd_pulse   (sfd_pulse),
        .txend_pulse (txend_pulse),
        .cap_sel     (cap_sel),
        .low_rd      (low_rd),
        .cap_q       (cap),
        .shadow_q    (shadow_hi)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_cfg_t cfg;
        assign cfg.lo_en  = cmp_lo_en[c];
        assign cfg.hi_en  = cmp_hi_en[c];
        assign cfg.lo_val = cmp_lo_val[c*RT_PW +: RT_PW];
        assign cfg.hi_val = cmp_hi_val[c*RT_OW +: RT_OW];

        rt_compare_ch u_ch (
            .clk    (clk),
            .rst    (rst),
            .now    (now),
            .cfg    (cfg),
            .clr    (clr_flags[c]),
            .evt_q  (evt[c]),
            .flag_q (flags[c])
        );
    end

    assign now_time = now;
    assign low_val  = now.cnt;
    assign cap_time = cap;
    assign irq      = |flags;

    p_irq_follows_flags_r8: assert property (@(posedge clk) disable iff (rst)
        irq == (flags != '0));
endmodule

// File: tb/sim_radio_evt_timer.sv
module sim_radio_evt_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [15:0] period_cfg = 16'd5;
    logic        sfd_pulse = 1'b0, txend_pulse = 1'b0, cap_sel = 1'b0, low_rd = 1'b0;
    logic [1:0]  clr_flags = '0, cmp_lo_en = '0, cmp_hi_en = '0;
    logic [31:0] cmp_lo_val = '0;
    logic [47:0] cmp_hi_val = '0;
    logic [39:0] now_time, cap_time;
    logic [15:0] low_val;
    logic [23:0] shadow_hi;
    logic [1:0]  evt, flags;
    logic        irq;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    radio_evt_timer u0 (.*);

    // reference model built from the requirements
    logic [15:0] m_cnt;  logic [23:0] m_ovf, m_sh;
    logic [39:0] m_cap;  logic [1:0] m_hd, m_evt, m_flag;

    function automatic logic m_hit(int c);
        logic lo_ok, hi_ok;
        lo_ok = !cmp_lo_en[c] || (m_cnt == cmp_lo_val[c*16 +: 16]);
        hi_ok = !cmp_hi_en[c] || (m_ovf == cmp_hi_val[c*24 +: 24]);
        return (cmp_lo_en[c] || cmp_hi_en[c]) && lo_ok && hi_ok;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0; m_ovf <= '0; m_sh <= '0; m_cap <= '0;
            m_hd <= '0; m_evt <= '0; m_flag <= '0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                m_hd[c]   <= m_hit(c);
                m_evt[c]  <= m_hit(c) && !m_hd[c];
                m_flag[c] <= (m_hit(c) && !m_hd[c]) || (m_flag[c] && !clr_flags[c]);
            end
            if (cap_sel ? txend_pulse : sfd_pulse) m_cap <= {m_ovf, m_cnt};
            if (low_rd) m_sh <= m_ovf;
            if (run) begin
                if (m_cnt >= period_cfg - 16'd1) begin
                    m_cnt <= '0; m_ovf <= m_ovf + 24'd1;
                end else m_cnt <= m_cnt + 16'd1;
            end
        end
    end

    task automatic chk(string tag, logic [39:0] act, logic [39:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, now_time, {m_ovf, m_cnt});
        chk("R9", {24'd0, low_val}, {24'd0, m_cnt});
        chk("R9", {16'd0, shadow_hi}, {16'd0, m_sh});
        chk("R4", cap_time, m_cap);
        chk("R6", {38'd0, evt}, {38'd0, m_evt});
        chk("R7", {38'd0, flags}, {38'd0, m_flag});
        chk("R8", {39'd0, irq}, {39'd0, |m_flag});
    endtask

    task automatic step(string tag, bit rnd_side, bit rnd_clr);
        @(negedge clk);
        cyc++;
        check_all(tag);
        if (rnd_side) begin
            sfd_pulse   = ($urandom % 4) == 0;
            txend_pulse = ($urandom % 4) == 0;
            cap_sel     = $urandom % 2;
            low_rd      = ($urandom % 3) == 0;
        end else begin
            sfd_pulse = 0; txend_pulse = 0; low_rd = 0;
        end
        if (rnd_clr) clr_flags = 2'($urandom);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; run = 0; clr_flags = '0;
        sfd_pulse = 0; txend_pulse = 0; low_rd = 0;
        @(negedge clk);
        @(negedge clk);
        // R1: everything zero after reset
        chk("R1", now_time, 40'd0);
        chk("R1", cap_time, 40'd0);
        chk("R1", {16'd0, shadow_hi}, 40'd0);
        chk("R1", {36'd0, evt, flags}, 40'd0);
        rst = 0;
    endtask

    always @(posedge clk) begin
        cyc <= cyc;
        if (!done) begin
            if (n_chk >= 0 && $time > 64'd800000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog: run did not finish");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        // R5 R6 R7: sweep of every enable combination and compare value
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int lo = 0; lo < 5; lo++) begin
                for (int hi = 1; hi < 3; hi++) begin
                    do_reset();
                    period_cfg = 16'd5; run = 1;
                    cmp_lo_en  = {~cfg[0], cfg[0]};
                    cmp_hi_en  = {~cfg[1], cfg[1]};
                    cmp_lo_val = {16'(4 - lo), 16'(lo)};
                    cmp_hi_val = {24'd3, 24'(hi)};
                    for (int k = 0; k < 30; k++) step("R5", 1, 1);
                end
            end
        end
        // R3: random run gating
        do_reset();
        period_cfg = 16'd5; cmp_lo_en = 2'b11; cmp_hi_en = 2'b00;
        cmp_lo_val = {16'd4, 16'd1};
        for (int k = 0; k < 200; k++) begin
            run = $urandom % 2;
            step("R3", 1, 1);
        end
        // R2: lowering the period below the current count
        do_reset();
        run = 1; period_cfg = 16'd20;
        for (int k = 0; k < 15; k++) step("R2", 1, 0);
        period_cfg = 16'd4;
        for (int k = 0; k < 20; k++) step("R2", 1, 0);
        // R7: clear held high collides with every flag set
        do_reset();
        period_cfg = 16'd5; run = 1; cmp_lo_en = 2'b01; cmp_hi_en = 2'b00;
        cmp_lo_val = {16'd0, 16'd2}; clr_flags = 2'b01;
        for (int k = 0; k < 20; k++) step("R7", 0, 0);
        clr_flags = 2'b00;
        for (int k = 0; k < 10; k++) step("R7", 0, 0);
        // R2: period 0 means 65536 counts per overflow step
        do_reset();
        period_cfg = 16'd0; run = 1; cmp_lo_en = 2'b00; cmp_hi_en = 2'b01;
        cmp_hi_val = {24'd0, 24'd1};
        for (int k = 0; k < 65545; k++) step("R2", (k % 97) == 0, 0);
        chk("R2", {16'd0, now_time[39:16]}, 40'd1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule